// File: doc/BRIEF.md
# Transfer Unit Parameter Calculator

This block works out two link configuration values for a single-stream video source that packs pixel data into fixed transfer units of 64 link symbols. It takes the pixel clock, the bits per pixel, the number of active lanes and the per-lane link symbol rate. From these it produces the number of valid symbols per transfer unit and the fill threshold at which the video FIFO starts being read. Both results are 6-bit values that can be loaded directly into configuration fields. The pixel clock and the link symbol rate must use the same frequency unit, for example kHz.

A request is made by pulsing `start_i` while the block is idle. The block then runs one shared bit-serial divider through up to four divisions. It raises `done_o` for one cycle when the new values are on `vs_o` and `thr_o`. Those outputs keep their values until the next request finishes. A request with a zero operand that would divide by zero is rejected in one cycle with an error flag.

Top module: `tu_param_calc`

## Requirements
- R1: When R = floor(8·pix·bpp / (lanes·rate)) is between 1 and 63, `vs_o` equals R after the request completes.
- R2: When R is 64 or more (required bandwidth equal to or above available), `vs_o` is 63.
- R3: When R is 0, `vs_o` is 1.
- R4: Let v be the reported `vs_o` value. F = floor(256·(v+1)/bpp), G = floor(32·(v+1)·pix/rate) and H = floor((G−32)/lanes) are values with 5 fraction bits. Then `thr_o` = floor((F−H)/32) + 2.
- R5: A threshold result above 63 is reported as 63.
- R6: If G < 32 or H > F (a negative intermediate), `thr_o` is 1.
- R7: A request with lanes, rate or bpp equal to zero produces `done_o` and `err_o` high in the cycle after `start_i`, and `vs_o`/`thr_o` keep their previous values. A valid request clears `err_o`.
- R8: `busy_o` is high from the cycle after an accepted valid request until `done_o`, and `done_o` is high for exactly one cycle per request.
- R9: `start_i` is ignored while `busy_o` is high, and `vs_o`/`thr_o` change only in a cycle where `done_o` is high.
- R10: After reset, `vs_o` is 0, `thr_o` is 32, and `done_o`, `err_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| pix_clk_i | input | FREQ_W | Pixel clock frequency |
| bpp_i | input | BPP_W | Bits per pixel |
| lanes_i | input | LANE_W | Active lane count |
| link_rate_i | input | FREQ_W | Per-lane link symbol rate, same unit as pixel clock |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request had a zero divisor operand |
| vs_o | output | 6 | Valid symbols per transfer unit |
| thr_o | output | 6 | Video FIFO start threshold |

## Verification
The bench builds the block with its default parameters: 20-bit frequencies, 6-bit bpp, 3-bit lane count, 64-symbol units and 5 fraction bits. These widths let a pixel clock near 1 GHz in kHz meet a very low link rate, which drives the valid-symbol count past 64. They also allow a bits-per-pixel value of 1, which is the only practical way to push the threshold past 63. Because odd lane counts up to 7 are legal inputs, the bench mixes them with the usual 1, 2 and 4 to exercise the truncation in the lane division.

// File: rtl/tu_calc_pkg.sv
// Package: shared state and step encodings for the transfer unit calculator.
// Assumes: nothing; holds only types.
package tu_calc_pkg;

    // Top-level sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } tu_state_e;

    // Which division the shared divider is working on.
    typedef enum logic [1:0] {
        STEP_VS,
        STEP_FULL,
        STEP_RATIO,
        STEP_LANE
    } tu_step_e;

endpackage

// File: rtl/tu_divider.sv
// Module: tu_divider
// Unsigned restoring divider that produces one quotient bit per clock.
// A start pulse loads the operands. done_o pulses once, NUM_W cycles later,
// and quo_o then holds the quotient until the next start.
// Assumes: den_i is non-zero whenever start_i is high.
module tu_divider #(
    parameter int NUM_W = 31,
    parameter int DEN_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] acc_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;

    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, acc_q[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end

    // Iteration register: shift the dividend in and the quotient bits out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !run_q) begin
                acc_q <= num_i;
                rem_q <= '0;
                den_q <= den_i;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= {acc_q[NUM_W-2:0], fits};
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = acc_q;

    // R1: the partial remainder stays below the divisor while iterating.
    p_rem_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < den_q));

    // R8: completion of a division is a single-cycle event.
    p_div_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/tu_operand_sel.sv
// Module: tu_operand_sel
// Chooses the dividend and divisor for each division step.
// VS    : pix*bpp*(TU/8) / (lanes*rate)
// FULL  : (v+1)*8*2^FRAC / bpp
// RATIO : (v+1)*pix*2^FRAC / rate
// LANE  : (G - 2^FRAC) / lanes
// Assumes: NUM_W can hold every dividend above without overflow.
module tu_operand_sel
    import tu_calc_pkg::*;
#(
    parameter int FREQ_W  = 20,
    parameter int BPP_W   = 6,
    parameter int LANE_W  = 3,
    parameter int FIELD_W = 6,
    parameter int TU_SIZE = 64,
    parameter int FRAC    = 5,
    parameter int NUM_W   = 31,
    parameter int DEN_W   = 23
) (
    input  tu_step_e           step_i,
    input  logic [FREQ_W-1:0]  pix_i,
    input  logic [BPP_W-1:0]   bpp_i,
    input  logic [LANE_W-1:0]  lanes_i,
    input  logic [FREQ_W-1:0]  rate_i,
    input  logic [FIELD_W-1:0] vs_i,
    input  logic [NUM_W-1:0]   g_adj_i,
    output logic [NUM_W-1:0]   num_o,
    output logic [DEN_W-1:0]   den_o
);
    localparam int BYTE_SCALE = TU_SIZE / 8;

    logic [NUM_W-1:0] vs_plus;

    // Operand multiplexer keyed by the current step.
    always_comb begin
        vs_plus = NUM_W'(vs_i) + NUM_W'(1);
        unique case (step_i)
            STEP_VS: begin
                num_o = NUM_W'(pix_i) * NUM_W'(bpp_i) * NUM_W'(BYTE_SCALE);
                den_o = DEN_W'(lanes_i) * DEN_W'(rate_i);
            end
            STEP_FULL: begin
                num_o = vs_plus << (FRAC + 3);
                den_o = DEN_W'(bpp_i);
            end
            STEP_RATIO: begin
                num_o = (vs_plus * NUM_W'(pix_i)) << FRAC;
                den_o = DEN_W'(rate_i);
            end
            default: begin
                num_o = g_adj_i;
                den_o = DEN_W'(lanes_i);
            end
        endcase
    end

endmodule

// File: rtl/tu_field_pack.sv
// Module: tu_field_pack
// Fits the raw results into the 6-bit output fields.
// The valid-symbol count is clamped to 1..MAX. The threshold becomes
// floor((F-H)/2^FRAC)+2, clamped to MAX, or 1 when an intermediate was negative.
// Assumes: f_i and h_i carry FRAC fraction bits.
module tu_field_pack #(
    parameter int NUM_W   = 31,
    parameter int FIELD_W = 6,
    parameter int FRAC    = 5
) (
    input  logic [NUM_W-1:0]   vs_raw_i,
    input  logic [NUM_W-1:0]   f_i,
    input  logic [NUM_W-1:0]   h_i,
    input  logic               neg_i,
    output logic [FIELD_W-1:0] vs_o,
    output logic [FIELD_W-1:0] thr_o
);
    localparam logic [NUM_W-1:0] FIELD_MAX = NUM_W'((1 << FIELD_W) - 1);

    logic [NUM_W-1:0] span;
    logic [NUM_W-1:0] whole;

    // Valid-symbol clamp into the legal 1..MAX range.
    always_comb begin
        if (vs_raw_i == '0) begin
            vs_o = FIELD_W'(1);
        end else if (vs_raw_i > FIELD_MAX) begin
            vs_o = FIELD_MAX[FIELD_W-1:0];
        end else begin
            vs_o = vs_raw_i[FIELD_W-1:0];
        end
    end

    // Threshold: drop the fraction, add the margin, then saturate.
    always_comb begin
        span  = f_i - h_i;
        whole = (span >> FRAC) + NUM_W'(2);
        if (neg_i || (h_i > f_i)) begin
            thr_o = FIELD_W'(1);
        end else if (whole > FIELD_MAX) begin
            thr_o = FIELD_MAX[FIELD_W-1:0];
        end else begin
            thr_o = whole[FIELD_W-1:0];
        end
    end

endmodule

// File: rtl/tu_param_calc.sv
// Module: tu_param_calc (top)
// Sequences the shared divider through the four divisions that give the
// valid-symbol count and the FIFO start threshold. It then loads the
// packed results into the output registers.
// Assumes: pix_clk_i and link_rate_i share one frequency unit, and the
// inputs are held stable only for the start cycle (they are captured).
module tu_param_calc
    import tu_calc_pkg::*;
#(
    parameter int FREQ_W  = 20,
    parameter int BPP_W   = 6,
    parameter int LANE_W  = 3,
    parameter int TU_SIZE = 64,
    parameter int FRAC    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] pix_clk_i,
    input  logic [BPP_W-1:0]  bpp_i,
    input  logic [LANE_W-1:0] lanes_i,
    input  logic [FREQ_W-1:0] link_rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [5:0]        vs_o,
    output logic [5:0]        thr_o
);
    localparam int FIELD_W = $clog2(TU_SIZE);
    localparam int NUM_A   = FREQ_W + FIELD_W + 1 + FRAC;
    localparam int NUM_B   = FREQ_W + BPP_W + $clog2(TU_SIZE / 8) + 1;
    localparam int NUM_W   = (NUM_A > NUM_B) ? NUM_A : NUM_B;
    localparam int DEN_W   = FREQ_W + LANE_W;
    localparam logic [NUM_W-1:0] ONE_FX = NUM_W'(1) << FRAC;
    localparam logic [FIELD_W-1:0] THR_RST = FIELD_W'(TU_SIZE / 2);

    tu_state_e          state_q;
    tu_step_e           step_q;
    logic [FREQ_W-1:0]  pix_q;
    logic [BPP_W-1:0]   bpp_q;
    logic [LANE_W-1:0]  lanes_q;
    logic [FREQ_W-1:0]  rate_q;
    logic [FIELD_W-1:0] v_q;
    logic [NUM_W-1:0]   f_q;
    logic [NUM_W-1:0]   g_adj_q;
    logic [NUM_W-1:0]   h_q;
    logic               neg_q;
    logic [FIELD_W-1:0] vs_out_q;
    logic [FIELD_W-1:0] thr_out_q;
    logic               done_q;
    logic               err_q;

    logic               bad_req;
    logic               div_start;
    logic               div_done;
    logic [NUM_W-1:0]   div_quo;
    logic [NUM_W-1:0]   div_num;
    logic [DEN_W-1:0]   div_den;
    logic [FIELD_W-1:0] vs_packed;
    logic [FIELD_W-1:0] thr_packed;

    // A zero divisor operand makes the request invalid.
    assign bad_req   = (lanes_i == '0) || (link_rate_i == '0) || (bpp_i == '0);
    assign div_start = (state_q == ST_LAUNCH);

    tu_operand_sel #(
        .FREQ_W  (FREQ_W),
        .BPP_W   (BPP_W),
        .LANE_W  (LANE_W),
        .FIELD_W (FIELD_W),
        .TU_SIZE (TU_SIZE),
        .FRAC    (FRAC),
        .NUM_W   (NUM_W),
        .DEN_W   (DEN_W)
    ) u_sel (
        .step_i  (step_q),
        .pix_i   (pix_q),
        .bpp_i   (bpp_q),
        .lanes_i (lanes_q),
        .rate_i  (rate_q),
        .vs_i    (v_q),
        .g_adj_i (g_adj_q),
        .num_o   (div_num),
        .den_o   (div_den)
    );

    tu_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    tu_field_pack #(
        .NUM_W   (NUM_W),
        .FIELD_W (FIELD_W),
        .FRAC    (FRAC)
    ) u_pack (
        .vs_raw_i (div_quo),
        .f_i      (f_q),
        .h_i      (h_q),
        .neg_i    (neg_q),
        .vs_o     (vs_packed),
        .thr_o    (thr_packed)
    );

    // Sequencer: capture, run the division chain, publish the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            step_q    <= STEP_VS;
            pix_q     <= '0;
            bpp_q     <= '0;
            lanes_q   <= '0;
            rate_q    <= '0;
            v_q       <= '0;
            f_q       <= '0;
            g_adj_q   <= '0;
            h_q       <= '0;
            neg_q     <= 1'b0;
            vs_out_q  <= '0;
            thr_out_q <= THR_RST;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (bad_req) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            pix_q   <= pix_clk_i;
                            bpp_q   <= bpp_i;
                            lanes_q <= lanes_i;
                            rate_q  <= link_rate_i;
                            step_q  <= STEP_VS;
                            neg_q   <= 1'b0;
                            h_q     <= '0;
                            state_q <= ST_LAUNCH;
                        end
                    end
                end
                ST_LAUNCH: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (div_done) begin
                        unique case (step_q)
                            STEP_VS: begin
                                v_q     <= vs_packed;
                                step_q  <= STEP_FULL;
                                state_q <= ST_LAUNCH;
                            end
                            STEP_FULL: begin
                                f_q     <= div_quo;
                                step_q  <= STEP_RATIO;
                                state_q <= ST_LAUNCH;
                            end
                            STEP_RATIO: begin
                                if (div_quo < ONE_FX) begin
                                    neg_q   <= 1'b1;
                                    state_q <= ST_FINISH;
                                end else begin
                                    g_adj_q <= div_quo - ONE_FX;
                                    step_q  <= STEP_LANE;
                                    state_q <= ST_LAUNCH;
                                end
                            end
                            default: begin
                                h_q     <= div_quo;
                                state_q <= ST_FINISH;
                            end
                        endcase
                    end
                end
                default: begin
                    vs_out_q  <= v_q;
                    thr_out_q <= thr_packed;
                    err_q     <= 1'b0;
                    done_q    <= 1'b1;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;
    assign vs_o   = vs_out_q;
    assign thr_o  = thr_out_q;

    // R8: the completion pulse lasts one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: a successful completion never reports zero valid symbols.
    p_vs_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (vs_o != '0));

    // R6: a successful completion never reports a zero threshold.
    p_thr_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (thr_o != '0));

    // R9: the result fields move only together with the completion pulse.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(vs_o) || !$stable(thr_o)) |-> done_o);

    // R7: an invalid request is answered on the next cycle, outputs untouched.
    p_err_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && bad_req) |=> (done_o && err_o && $stable(vs_o) && $stable(thr_o)));

    // R8: an accepted valid request keeps the block busy until completion.
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !bad_req) |=> (busy_o && !done_o));

endmodule

// File: tb/tu_param_calc_bench.sv
module tu_param_calc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [19:0] pix_clk_i = '0;
    logic [5:0]  bpp_i = '0;
    logic [2:0]  lanes_i = '0;
    logic [19:0] link_rate_i = '0;
    logic        busy_o;
    logic        done_o;
    logic        err_o;
    logic [5:0]  vs_o;
    logic [5:0]  thr_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tu_param_calc u_tu_param_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pix_clk_i   (pix_clk_i),
        .bpp_i       (bpp_i),
        .lanes_i     (lanes_i),
        .link_rate_i (link_rate_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .vs_o        (vs_o),
        .thr_o       (thr_o)
    );

    function automatic longint raw_vs(longint p, longint b, longint l, longint r);
        return (p * b * 8) / (l * r);
    endfunction

    function automatic longint exp_vs(longint p, longint b, longint l, longint r);
        longint q;
        q = raw_vs(p, b, l, r);
        if (q == 0) return 1;
        if (q > 63) return 63;
        return q;
    endfunction

    function automatic longint exp_thr(longint p, longint b, longint l, longint r);
        longint v, f, g, h, t;
        v = exp_vs(p, b, l, r);
        f = (256 * (v + 1)) / b;
        g = (32 * (v + 1) * p) / r;
        if (g < 32) return 1;
        h = (g - 32) / l;
        if (h > f) return 1;
        t = ((f - h) >> 5) + 2;
        if (t > 63) return 63;
        return t;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 2000; i++) begin
            if (done_o) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Drive a request and compare both fields with the bench model.
    task automatic run_check(longint p, longint b, longint l, longint r);
        bit seen;
        longint rv, ev, et;
        string vtag, ttag;
        @(negedge clk);
        pix_clk_i = 20'(p); bpp_i = 6'(b); lanes_i = 3'(l); link_rate_i = 20'(r);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        check(seen, "R8", "done seen", seen, 1);
        rv = raw_vs(p, b, l, r);
        ev = exp_vs(p, b, l, r);
        et = exp_thr(p, b, l, r);
        vtag = (rv == 0) ? "R3" : ((rv > 63) ? "R2" : "R1");
        ttag = (et == 63) ? "R5" : ((et == 1) ? "R6" : "R4");
        check(vs_o == 6'(ev), vtag, "vs", vs_o, ev);
        check(thr_o == 6'(et), ttag, "thr", thr_o, et);
        check(err_o == 1'b0, "R7", "err clear", err_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R8", "done one cycle", done_o, 0);
    endtask

    task automatic bad_check(longint p, longint b, longint l, longint r);
        logic [5:0] pv, pt;
        pv = vs_o; pt = thr_o;
        @(negedge clk);
        pix_clk_i = 20'(p); bpp_i = 6'(b); lanes_i = 3'(l); link_rate_i = 20'(r);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && err_o, "R7", "error done", {done_o, err_o}, 3);
        check(vs_o == pv, "R7", "vs kept", vs_o, pv);
        check(thr_o == pt, "R7", "thr kept", thr_o, pt);
        check(busy_o == 1'b0, "R7", "not busy", busy_o, 0);
    endtask

    function automatic longint pick_bpp(int k);
        case (k)
            0: return 18; 1: return 24; 2: return 30; 3: return 36;
            4: return 48; 5: return 8;  default: return 1 + $urandom_range(0, 62);
        endcase
    endfunction

    function automatic longint pick_rate(int k);
        case (k)
            0: return 162000; 1: return 270000; 2: return 540000;
            3: return 810000; default: return 1000 + $urandom_range(0, 900000);
        endcase
    endfunction

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit seen;
        logic [5:0] hv, ht;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(vs_o == 6'd0, "R10", "reset vs", vs_o, 0);
        check(thr_o == 6'd32, "R10", "reset thr", thr_o, 32);
        check({done_o, err_o, busy_o} == 3'b000, "R10", "reset flags", {done_o, err_o, busy_o}, 0);

        // Directed corners
        run_check(31500, 24, 4, 162000);     // R1 ordinary, thr 5
        run_check(54000, 24, 1, 162000);     // R2 bandwidths equal -> 63
        run_check(900000, 36, 1, 50000);     // R2 oversubscribed
        run_check(1000, 18, 4, 810000);      // R3 zero raised to 1
        run_check(1000000, 1, 1, 250000);    // R5 threshold saturates
        run_check(1000, 8, 4, 810000);       // R6 negative intermediate
        run_check(148500, 24, 3, 270000);    // R4 odd lane count

        // R7 invalid requests
        bad_check(100000, 24, 0, 270000);
        bad_check(100000, 24, 2, 0);
        bad_check(100000, 0, 2, 270000);
        run_check(148500, 24, 4, 270000);    // R7 valid request clears err

        // R8 busy and R9 start ignored while busy
        @(negedge clk);
        pix_clk_i = 20'd148500; bpp_i = 6'd24; lanes_i = 3'd2; link_rate_i = 20'd270000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        repeat (5) @(negedge clk);
        pix_clk_i = 20'd30000; bpp_i = 6'd18; lanes_i = 3'd4; link_rate_i = 20'd810000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        check(seen, "R9", "done seen", seen, 1);
        check(vs_o == 6'(exp_vs(148500, 24, 2, 270000)), "R9", "vs ignores busy start",
              vs_o, exp_vs(148500, 24, 2, 270000));
        check(thr_o == 6'(exp_thr(148500, 24, 2, 270000)), "R9", "thr ignores busy start",
              thr_o, exp_thr(148500, 24, 2, 270000));
        hv = vs_o; ht = thr_o;
        repeat (20) @(negedge clk);
        check(vs_o == hv && thr_o == ht, "R9", "outputs held", {vs_o, thr_o}, {hv, ht});
        check(busy_o == 1'b0, "R8", "idle after done", busy_o, 0);

        // Constrained random
        for (int n = 0; n < 250; n++) begin
            longint p, b, l, r;
            p = 5000 + $urandom_range(0, 1000000);
            b = pick_bpp($urandom_range(0, 7));
            l = 1 + $urandom_range(0, 6);
            r = pick_rate($urandom_range(0, 5));
            run_check(p, b, l, r);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule